// File: doc/BRIEF.md
# Serial DAC Write Controller

This controller sits on the host side of a 16-bit serial digital-to-analog converter and turns parallel codes into the pin sequence that converter expects. A word arrives on a valid/ready handshake. The controller first drives the address pair to the shift code. It then clocks the word out most-significant bit first on the rising edges of a serial clock. Next it switches the address pair to the load code and gives one extra clock pulse, so the converter copies its shift register into the output latch. A separate request pulses the converter's active-low clear line.

All timing is counted in system-clock cycles. Each minimum interval is given in nanoseconds, and the block converts it to a cycle count by rounding up ns × MHz / 1000. The intervals are the clock low and high phases, the address and data setup and hold, and the clear pulse width. With the default 100 MHz clock, a clock low phase lasts 5 cycles and a high phase lasts 5 cycles. Setup windows are 5 cycles, the hold is 1 cycle and the clear pulse is 20 cycles.

Between transfers the serial clock rests high and both address lines rest high, which the converter treats as "no change". Stray activity on the lines therefore has no effect.

Top module: `dac_wr_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, `wr_ready`=1, `dac_sclk`=1, `dac_a0`=1, `dac_a1`=1 and `dac_clr_n`=1.
- R2: During the shift phase the address pair is A0=0, A1=1. Exactly 16 rising edges of `dac_sclk` occur in that phase, and on them `dac_sdi` carries the word most-significant bit first.
- R3: After the 16th bit the address pair becomes A0=1, A1=0 and one further rising edge occurs. The converter latch then holds exactly the accepted word.
- R4: Every low phase of `dac_sclk` lasts at least 5 cycles and every high phase within a transfer at least 5 cycles (defaults).
- R5: `dac_sdi` and the address pair are unchanged for at least 5 cycles before each rising edge of `dac_sclk`. They do not change in the cycle of a rising edge.
- R6: `wr_ready` is low from the accepting edge for exactly 180 cycles: 5 + 16×10 + 5 + 5 + 5. It then returns high when no clear is pending.
- R7: A clear request drives `dac_clr_n` low for exactly 20 cycles, with `dac_sclk` and both address lines high and `wr_ready` low.
- R8: A clear requested during a transfer is held pending. `dac_clr_n` stays high until the word has been loaded, and the clear pulse then starts one idle cycle later.
- R9: If `clr_req` and `wr_valid` are both high in an idle cycle, `wr_ready` is 0 in that cycle and the word is not taken; only the clear pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Word offered |
| wr_data | input | 16 | Code to be written |
| wr_ready | output | 1 | Controller can take a word this cycle |
| clr_req | input | 1 | One-cycle request to clear the converter |
| dac_sclk | output | 1 | Serial clock to the converter, idle high |
| dac_sdi | output | 1 | Serial data to the converter |
| dac_a0 | output | 1 | Address line 0 |
| dac_a1 | output | 1 | Address line 1 |
| dac_clr_n | output | 1 | Active-low clear to the converter |

## Verification
The hardest situations to create are a clear request that lands in the middle of a word and a clear that coincides with a new word in an idle cycle. In both, ordering decides whether the converter latch ends up holding the word or zero.

The bench models the converter from the pins alone. It shifts on rising serial-clock edges under the shift code, latches under the load code and zeroes on the clear line. It pulses `clr_req` thirty cycles into a transfer and again in the same cycle as `wr_valid` while idle. It then compares the latch contents and the number of loads seen before the clear fell, alongside per-edge timing measurements.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_ASET,
        ST_SLOW,
        ST_SHIGH,
        ST_LSET,
        ST_LLOW,
        ST_LHIGH
    } phase_e;

    // minimum time in ns -> whole system-clock cycles, rounded up, at least one
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dac_word_shifter.sv
module dac_word_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              shift,
    output logic              msb
);

    logic [DATA_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = din;
        end else if (shift) begin
            sh_d = {sh_q[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb = sh_q[DATA_W-1];

endmodule

// File: rtl/dac_wr_ctrl.sv
module dac_wr_ctrl #(
    parameter int DATA_W     = 16,
    parameter int SYS_MHZ    = 100,
    parameter int T_HALF_NS  = 50,
    parameter int T_SETUP_NS = 50,
    parameter int T_HOLD_NS  = 10,
    parameter int T_CLR_NS   = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              clr_req,
    output logic              dac_sclk,
    output logic              dac_sdi,
    output logic              dac_a0,
    output logic              dac_a1,
    output logic              dac_clr_n
);
    import dac_wr_pkg::*;

    localparam int HALF_C = ns_to_cyc(T_HALF_NS,  SYS_MHZ);
    localparam int SET_C  = ns_to_cyc(T_SETUP_NS, SYS_MHZ);
    localparam int HOLD_C = ns_to_cyc(T_HOLD_NS,  SYS_MHZ);
    localparam int CLR_C  = ns_to_cyc(T_CLR_NS,   SYS_MHZ);
    localparam int LOW_C  = imax(HALF_C, SET_C);
    localparam int HIGH_C = imax(HALF_C, HOLD_C);
    localparam int MAX_C  = imax(imax(LOW_C, HIGH_C), imax(SET_C, CLR_C));
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam int BIT_W  = $clog2(DATA_W);

    localparam logic [CNT_W-1:0] SET_V  = CNT_W'(SET_C - 1);
    localparam logic [CNT_W-1:0] LOW_V  = CNT_W'(LOW_C - 1);
    localparam logic [CNT_W-1:0] HIGH_V = CNT_W'(HIGH_C - 1);
    localparam logic [CNT_W-1:0] CLR_V  = CNT_W'(CLR_C - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e           st;
        logic [BIT_W-1:0] bits;
        logic             sclk;
        logic             a0;
        logic             a1;
        logic             clr_n;
        logic             pend;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_exp;
    logic             sh_load;
    logic             sh_shift;

    dac_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    dac_word_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .din   (wr_data),
        .shift (sh_shift),
        .msb   (dac_sdi)
    );

    always_comb begin
        r_d      = r_q;
        t_load   = 1'b0;
        t_val    = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        r_d.pend = r_q.pend | clr_req;

        unique case (r_q.st)
            ST_IDLE: begin
                if (clr_req || r_q.pend) begin
                    r_d.st    = ST_CLR;
                    r_d.clr_n = 1'b0;
                    r_d.pend  = 1'b0;
                    t_load    = 1'b1;
                    t_val     = CLR_V;
                end else if (wr_valid) begin
                    r_d.st   = ST_ASET;
                    r_d.a0   = 1'b0;
                    r_d.a1   = 1'b1;
                    r_d.bits = '0;
                    sh_load  = 1'b1;
                    t_load   = 1'b1;
                    t_val    = SET_V;
                end
            end
            ST_CLR: begin
                if (t_exp) begin
                    r_d.st    = ST_IDLE;
                    r_d.clr_n = 1'b1;
                end
            end
            ST_ASET: begin
                if (t_exp) begin
                    r_d.st   = ST_SLOW;
                    r_d.sclk = 1'b0;
                    t_load   = 1'b1;
                    t_val    = LOW_V;
                end
            end
            ST_SLOW: begin
                if (t_exp) begin
                    r_d.st   = ST_SHIGH;
                    r_d.sclk = 1'b1;
                    t_load   = 1'b1;
                    t_val    = HIGH_V;
                end
            end
            ST_SHIGH: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    if (r_q.bits == LAST_BIT) begin
                        r_d.st = ST_LSET;
                        r_d.a0 = 1'b1;
                        r_d.a1 = 1'b0;
                        t_val  = SET_V;
                    end else begin
                        r_d.st   = ST_SLOW;
                        r_d.sclk = 1'b0;
                        r_d.bits = r_q.bits + 1'b1;
                        sh_shift = 1'b1;
                        t_val    = LOW_V;
                    end
                end
            end
            ST_LSET: begin
                if (t_exp) begin
                    r_d.st   = ST_LLOW;
                    r_d.sclk = 1'b0;
                    t_load   = 1'b1;
                    t_val    = LOW_V;
                end
            end
            ST_LLOW: begin
                if (t_exp) begin
                    r_d.st   = ST_LHIGH;
                    r_d.sclk = 1'b1;
                    t_load   = 1'b1;
                    t_val    = HIGH_V;
                end
            end
            ST_LHIGH: begin
                if (t_exp) begin
                    r_d.st = ST_IDLE;
                    r_d.a0 = 1'b1;
                    r_d.a1 = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.bits  <= '0;
            r_q.sclk  <= 1'b1;
            r_q.a0    <= 1'b1;
            r_q.a1    <= 1'b1;
            r_q.clr_n <= 1'b1;
            r_q.pend  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_ready  = (r_q.st == ST_IDLE) && !r_q.pend && !clr_req;
    assign dac_sclk  = r_q.sclk;
    assign dac_a0    = r_q.a0;
    assign dac_a1    = r_q.a1;
    assign dac_clr_n = r_q.clr_n;

endmodule

// File: rtl/dac_wr_ctrl_chk.sv
module dac_wr_ctrl_chk #(
    parameter int LOW_C  = 5,
    parameter int HIGH_C = 5,
    parameter int SET_C  = 5
) (
    input logic clk,
    input logic rst_n,
    input logic wr_ready,
    input logic dac_sclk,
    input logic dac_sdi,
    input logic dac_a0,
    input logic dac_a1,
    input logic dac_clr_n
);

    logic [15:0] low_len, high_len, sdi_age;
    logic        sdi_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len  <= '0;
            high_len <= '0;
            sdi_age  <= '0;
            sdi_prev <= 1'b0;
        end else begin
            low_len  <= dac_sclk ? '0 : ((low_len == 16'hFFFF) ? low_len : low_len + 1'b1);
            high_len <= !dac_sclk ? '0 : ((high_len == 16'hFFFF) ? high_len : high_len + 1'b1);
            sdi_prev <= dac_sdi;
            sdi_age  <= (dac_sdi != sdi_prev) ? 16'd1 :
                        ((sdi_age == 16'hFFFF) ? sdi_age : sdi_age + 1'b1);
        end
    end

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (dac_sclk && dac_a0 && dac_a1 && dac_clr_n));

    p_pulse_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_sclk |-> (dac_a0 != dac_a1));

    p_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> (low_len >= 16'(LOW_C)));

    p_high_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sclk) |-> (high_len >= 16'(HIGH_C)));

    p_addr_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> $stable({dac_a0, dac_a1}));

    p_data_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dac_sclk) && !dac_a0) |-> ((dac_sdi == sdi_prev) && (sdi_age >= 16'(SET_C))));

    p_clr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clr_n |-> (dac_sclk && dac_a0 && dac_a1 && !wr_ready));

    p_clr_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_clr_n) |-> ($past(dac_a0) && $past(dac_a1) && $past(dac_sclk)));

endmodule

bind dac_wr_ctrl dac_wr_ctrl_chk #(
    .LOW_C  (LOW_C),
    .HIGH_C (HIGH_C),
    .SET_C  (SET_C)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ready  (wr_ready),
    .dac_sclk  (dac_sclk),
    .dac_sdi   (dac_sdi),
    .dac_a0    (dac_a0),
    .dac_a1    (dac_a1),
    .dac_clr_n (dac_clr_n)
);

// File: tb/sim_dac_wr_ctrl.sv
`timescale 1ns/1ps
module sim_dac_wr_ctrl;

    localparam int LOW_EXP  = 5;
    localparam int HIGH_EXP = 5;
    localparam int SET_EXP  = 5;
    localparam int CLR_EXP  = 20;
    localparam int BUSY_EXP = SET_EXP + 16 * (LOW_EXP + HIGH_EXP) + SET_EXP + LOW_EXP + HIGH_EXP;
    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{16'h1234, 16'h0001, 16'hFFFF, 16'h0000, 16'hC3A5, 16'h8000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_ready;
    logic        clr_req = 1'b0;
    logic        dac_sclk, dac_sdi, dac_a0, dac_a1, dac_clr_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dac_wr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .clr_req(clr_req), .dac_sclk(dac_sclk),
        .dac_sdi(dac_sdi), .dac_a0(dac_a0), .dac_a1(dac_a1), .dac_clr_n(dac_clr_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pin-level model of the converter
    logic [15:0] rx = '0, dac_latch = '0, last_load = '0;
    int nbits = 0, bits_at_load = 0, nload = 0, nload_at_clr = -1;

    always @(posedge dac_sclk or negedge dac_clr_n) begin
        if (!dac_clr_n) begin
            dac_latch    <= '0;
            nload_at_clr <= nload;
        end else if (rst_n) begin
            case ({dac_a0, dac_a1})
                2'b01: begin rx <= {rx[14:0], dac_sdi}; nbits <= nbits + 1; end
                2'b10: begin
                    dac_latch <= rx; last_load <= rx; nload <= nload + 1;
                    bits_at_load <= nbits; nbits <= 0;
                end
                default: ;
            endcase
        end
    end

    // per-cycle timing monitor (sampled away from the active edge)
    logic p_sclk = 1'b1, p_sdi = 1'b0;
    logic [1:0] p_adr = 2'b11;
    int lowrun = 0, highrun = 0, sdi_age = 100, adr_age = 100, since_rise = 100;

    always @(negedge clk) begin
        if (rst_n) begin
            sdi_age    = (dac_sdi != p_sdi) ? 0 : sdi_age + 1;
            adr_age    = ({dac_a0, dac_a1} != p_adr) ? 0 : adr_age + 1;
            since_rise = since_rise + 1;
            if (dac_sclk && !p_sclk) begin
                chk(lowrun >= LOW_EXP, "R4 low phase", lowrun, LOW_EXP);
                chk(adr_age >= SET_EXP, "R5 address setup", adr_age, SET_EXP);
                if ({dac_a0, dac_a1} == 2'b01)
                    chk(sdi_age >= SET_EXP, "R5 data setup", sdi_age, SET_EXP);
                lowrun = 0; since_rise = 0;
            end
            if (!dac_sclk && p_sclk) begin
                chk(highrun >= HIGH_EXP, "R4 high phase", highrun, HIGH_EXP);
                highrun = 0;
            end
            if ((dac_sdi != p_sdi) || ({dac_a0, dac_a1} != p_adr))
                chk(since_rise >= 1, "R5 hold after rise", since_rise, 1);
            if (!dac_sclk) lowrun++; else highrun++;
            p_sclk = dac_sclk; p_sdi = dac_sdi; p_adr = {dac_a0, dac_a1};
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // offer a word and count cycles with ready low afterwards
    task automatic send(input logic [15:0] w, input int pulse_clr_at, output int busy);
        busy = 0;
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1; wr_data = w;
        @(negedge clk);
        wr_valid = 1'b0;
        while (!wr_ready) begin
            busy++;
            clr_req = (busy == pulse_clr_at);
            @(negedge clk);
            clr_req = 1'b0;
        end
    endtask

    task automatic idle_lines(input string tag);
        chk(wr_ready && dac_sclk && dac_a0 && dac_a1 && dac_clr_n, tag,
            {wr_ready, dac_sclk, dac_a0, dac_a1, dac_clr_n}, 5'b11111);
    endtask

    initial begin
        int busy, clr_low, n0;
        repeat (3) @(negedge clk);
        idle_lines("R1 lines during reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_lines("R1 lines after reset");

        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i], -1, busy);
            chk(dac_latch == VEC[i], "R3 latched word", dac_latch, VEC[i]);
            chk(bits_at_load == 16, "R2 bits per frame", bits_at_load, 16);
            chk(busy == BUSY_EXP, "R6 ready low span", busy, BUSY_EXP);
            idle_lines("R1 idle after word");
        end

        // R7: clear from idle
        @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        clr_low = 0;
        while (!dac_clr_n) begin clr_low++; @(negedge clk); end
        chk(clr_low == CLR_EXP, "R7 clear width", clr_low, CLR_EXP);
        chk(dac_latch == 16'h0, "R7 latch cleared", dac_latch, 0);
        idle_lines("R1 idle after clear");

        // R8: clear mid-transfer is deferred
        n0 = nload;
        send(16'h3C3C, 30, busy);
        chk(busy == BUSY_EXP + 1 + CLR_EXP, "R8 ready low incl. deferred clear", busy, BUSY_EXP + 1 + CLR_EXP);
        chk(last_load == 16'h3C3C, "R8 word loaded before clear", last_load, 16'h3C3C);
        chk(nload_at_clr == n0 + 1, "R8 clear after load", nload_at_clr, n0 + 1);
        chk(dac_latch == 16'h0, "R8 latch zero after clear", dac_latch, 0);

        // R9: clear and word in the same idle cycle
        send(16'h5A5A, -1, busy);
        n0 = nload;
        @(negedge clk);
        clr_req = 1'b1; wr_valid = 1'b1; wr_data = 16'h0F0F;
        #1;
        chk(wr_ready == 1'b0, "R9 ready low with clear", wr_ready, 0);
        @(negedge clk);
        clr_req = 1'b0; wr_valid = 1'b0;
        chk(dac_clr_n == 1'b0, "R9 clear taken", dac_clr_n, 0);
        repeat (CLR_EXP + 5) @(negedge clk);
        repeat (BUSY_EXP + 10) @(negedge clk);
        chk(nload == n0, "R9 word not taken", nload, n0);
        chk(dac_latch == 16'h0, "R9 latch stays clear", dac_latch, 0);
        idle_lines("R1 idle at end");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule